// File: doc/BRIEF.md
# Byte/Word ALU with Condition Flags

This block is a combinational arithmetic and logic unit for 16-bit data paths. Each operation works either on full 16-bit words or on the low byte only. It returns the result together with six condition flags: carry, parity, auxiliary carry, zero, sign and overflow. The flags follow the legacy conventions of that flag set. Subtraction reports a borrow in the carry flag. Parity always looks at the low byte. The auxiliary flag reports the carry across the nibble boundary. The sign, carry and overflow flags are taken at bit 7 or bit 15, depending on the operand size.

An execution stage places two operands, an operation code, a size select and the current carry on the inputs. It reads the result and the live flags in the same cycle. A registered copy of the flags is loaded on each clock edge where the enable strobe is high, so the stage can commit the flags only for the instructions that write them. For increment, decrement and complement the incoming carry is passed through unchanged, and a separate output marks these operations.

Top module: `alu_flags_unit`

## Requirements
- R1: ADD (code 0) returns (A+B) mod 2^n and ignores carry_in. ADC (code 1) returns (A+B+carry_in) mod 2^n. For both, CF is the carry out of the size MSB. n is 16 for a word and 8 for a byte.
- R2: SUB (code 2) returns (A-B) mod 2^n and SBB (code 3) returns (A-B-carry_in) mod 2^n. CF is set when the subtrahend, including any borrow-in, exceeds A; this is a borrow.
- R3: For add, subtract, increment and decrement, OF is set exactly when the signed result does not fit in n bits, that is, when the carry (or borrow) into the MSB differs from the one out of it.
- R4: AF is the carry out of bit 3 for additions and the borrow into bit 4 for subtractions (including INC and DEC). AF is 0 for all other operations.
- R5: PF is 1 when the low byte of the result holds an even number of 1 bits, in both byte and word mode.
- R6: ZF is 1 when the n-bit result is zero. SF equals the result MSB: bit 7 in byte mode, bit 15 in word mode. The flag vectors are packed as {OF,SF,ZF,AF,PF,CF}, with OF at bit 5 and CF at bit 0.
- R7: When size_word is 0, the upper bytes of op_a and op_b have no effect and result[15:8] is 0.
- R8: AND (4), OR (5) and XOR (6) return the bitwise function of A and B, with CF, OF and AF at 0.
- R9: INC (7) returns A+1 and DEC (8) returns A-1. NOT (9) returns ~A, with OF and AF at 0. For all three, CF equals carry_in and cf_keep is 1; for every other code cf_keep is 0.
- R10: SHL (10) shifts left by one, and CF takes the old MSB. SHR (11) shifts right by one with zero fill. SAR (12) shifts right by one with sign fill. For SHR and SAR, CF takes the old bit 0. OF is result-MSB XOR CF for SHL, the old MSB for SHR, and 0 for SAR. AF is 0 for all three.
- R11: flags_q resets to 0. It loads flags_now on a clock edge where flag_en is 1 and holds its value otherwise.
- R12: Codes 13 to 15 are reserved. They return result 0 with CF, OF, AF and SF at 0, which sets ZF=1 and PF=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_code | input | 4 | Operation select (codes in R1-R12 text) |
| size_word | input | 1 | 1 = word operation, 0 = byte operation |
| carry_in | input | 1 | Incoming carry flag |
| flag_en | input | 1 | Load strobe for flags_q |
| result | output | 16 | Operation result |
| flags_now | output | 6 | Combinational flags {OF,SF,ZF,AF,PF,CF} |
| flags_q | output | 6 | Registered flags, same packing |
| cf_keep | output | 1 | High when CF is passed through from carry_in |

## Verification
The bench targets the size boundaries. It checks 0x7F+1 against 0x7FFF+1 and 0xFF+1 against 0xFFFF+1, with junk in the upper operand bytes. A design that took its carry, sign or overflow from the wrong bit, or that let the upper byte leak in, would show a wrong CF, SF or OF there, or a non-zero upper result byte. Borrow cases such as 0-1 and 0x8000-1 would expose an inverted carry convention or a missing borrow-in on SBB. Increment of 0xFFFF with carry_in at both 0 and 1 would catch a unit that lets INC and DEC touch CF. Word results with an odd-parity high byte would catch a parity taken over the full word. A long pseudo-random sweep over every code, both sizes and both carry values compares against an arithmetic model built on integer comparisons rather than carry chains.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  localparam int FLAG_W = 6;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8,
    OP_NOT = 4'd9,
    OP_SHL = 4'd10,
    OP_SHR = 4'd11,
    OP_SAR = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } alu_flags_t;

  // even number of ones in the byte
  function automatic logic even_parity8(input logic [BYTE_W-1:0] v);
    return ~(^v);
  endfunction

  // carry vector from operands and sum: bit i is carry into bit i
  function automatic logic [31:0] carry_into(input logic [31:0] a,
                                             input logic [31:0] b,
                                             input logic [31:0] s);
    return a ^ b ^ s;
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_sub,
  input  logic              cin,
  input  logic              size_word,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              cin_msb,
  output logic              af
);
  import alu_flags_pkg::*;

  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W:0]   full;
  logic [DATA_W:0]   cin_ext;
  logic [31:0]       cvec;

  always_comb begin
    cin_ext = {{DATA_W{1'b0}}, cin};
    if (is_sub) full = {1'b0, a} - {1'b0, b} - cin_ext;
    else        full = {1'b0, a} + {1'b0, b} + cin_ext;
    cvec = carry_into(32'(a), 32'(b), 32'(full[DATA_W-1:0]));
  end

  always_comb begin
    if (size_word) begin
      res     = full[DATA_W-1:0];
      cout    = full[DATA_W];
      cin_msb = cvec[DATA_W-1];
    end else begin
      res     = {{HI_W{1'b0}}, full[BYTE_W-1:0]};
      cout    = full[BYTE_W];
      cin_msb = cvec[BYTE_W-1];
    end
    af = cvec[4];
  end

endmodule

// File: rtl/alu_shift_logic.sv
module alu_shift_logic #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        op,
  input  logic              size_word,
  output logic [DATA_W-1:0] res,
  output logic              sh_cf,
  output logic              sh_of
);
  import alu_flags_pkg::*;

  localparam int HI_W = DATA_W - BYTE_W;

  logic              msb_old;
  logic              msb_next;
  logic [DATA_W-1:0] raw;

  assign msb_old  = size_word ? a[DATA_W-1] : a[BYTE_W-1];
  assign msb_next = size_word ? a[DATA_W-2] : a[BYTE_W-2];

  always_comb begin
    raw   = '0;
    sh_cf = 1'b0;
    sh_of = 1'b0;
    case (op)
      OP_AND: raw = a & b;
      OP_OR:  raw = a | b;
      OP_XOR: raw = a ^ b;
      OP_NOT: raw = ~a;
      OP_SHL: begin
        raw   = a << 1;
        sh_cf = msb_old;
        sh_of = msb_next ^ msb_old;
      end
      OP_SHR: begin
        raw   = a >> 1;
        sh_cf = a[0];
        sh_of = msb_old;
      end
      OP_SAR: begin
        raw = a >> 1;
        if (size_word) raw[DATA_W-1] = msb_old;
        else           raw[BYTE_W-1] = msb_old;
        sh_cf = a[0];
      end
      default: raw = '0;
    endcase
    res = size_word ? raw : {{HI_W{1'b0}}, raw[BYTE_W-1:0]};
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res,
  input  logic              size_word,
  output logic              zf,
  output logic              sf,
  output logic              pf
);
  import alu_flags_pkg::*;

  assign zf = size_word ? (res == '0) : (res[BYTE_W-1:0] == '0);
  assign sf = size_word ? res[DATA_W-1] : res[BYTE_W-1];
  assign pf = even_parity8(res[BYTE_W-1:0]);

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        op_code,
  input  logic              size_word,
  input  logic              carry_in,
  input  logic              flag_en,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        flags_now,
  output logic [5:0]        flags_q,
  output logic              cf_keep
);
  import alu_flags_pkg::*;

  localparam int HI_W = DATA_W - BYTE_W;

  // operand masking for byte mode
  logic [DATA_W-1:0] a_m, b_m;
  assign a_m = size_word ? op_a : {{HI_W{1'b0}}, op_a[BYTE_W-1:0]};
  assign b_m = size_word ? op_b : {{HI_W{1'b0}}, op_b[BYTE_W-1:0]};

  // decode, brought out as named events
  logic is_arith, is_logic, is_shift, is_sub, is_incdec, use_cin, is_rsvd;
  always_comb begin
    is_arith  = 1'b0; is_logic = 1'b0; is_shift = 1'b0; is_sub = 1'b0;
    is_incdec = 1'b0; use_cin  = 1'b0; cf_keep  = 1'b0; is_rsvd = 1'b0;
    case (op_code)
      OP_ADD: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; use_cin = 1'b1; end
      OP_SUB: begin is_arith = 1'b1; is_sub = 1'b1; end
      OP_SBB: begin is_arith = 1'b1; is_sub = 1'b1; use_cin = 1'b1; end
      OP_AND, OP_OR, OP_XOR: is_logic = 1'b1;
      OP_INC: begin is_arith = 1'b1; is_incdec = 1'b1; cf_keep = 1'b1; end
      OP_DEC: begin is_arith = 1'b1; is_incdec = 1'b1; is_sub = 1'b1; cf_keep = 1'b1; end
      OP_NOT: cf_keep = 1'b1;
      OP_SHL, OP_SHR, OP_SAR: is_shift = 1'b1;
      default: is_rsvd = 1'b1;
    endcase
  end

  // arithmetic path
  logic [DATA_W-1:0] ar_b, ar_res;
  logic              ar_cin, ar_cout, ar_cin_msb, ar_af;
  assign ar_b   = is_incdec ? {{(DATA_W-1){1'b0}}, 1'b1} : b_m;
  assign ar_cin = use_cin & carry_in;

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a(a_m), .b(ar_b), .is_sub(is_sub), .cin(ar_cin), .size_word(size_word),
    .res(ar_res), .cout(ar_cout), .cin_msb(ar_cin_msb), .af(ar_af)
  );

  // logic and shift path
  logic [DATA_W-1:0] sl_res;
  logic              sl_cf, sl_of;
  alu_shift_logic #(.DATA_W(DATA_W)) u_shlog (
    .a(a_m), .b(b_m), .op(op_code), .size_word(size_word),
    .res(sl_res), .sh_cf(sl_cf), .sh_of(sl_of)
  );

  assign result = is_arith ? ar_res : sl_res;

  // result-derived flags
  logic zf_w, sf_w, pf_w;
  alu_flag_gen #(.DATA_W(DATA_W)) u_fgen (
    .res(result), .size_word(size_word), .zf(zf_w), .sf(sf_w), .pf(pf_w)
  );

  alu_flags_t fl;
  always_comb begin
    fl.zf = zf_w;
    fl.sf = sf_w;
    fl.pf = pf_w;
    fl.af = is_arith & ar_af;
    if (cf_keep)       fl.cf = carry_in;
    else if (is_arith) fl.cf = ar_cout;
    else if (is_shift) fl.cf = sl_cf;
    else               fl.cf = 1'b0;
    if (is_arith)      fl.of = ar_cout ^ ar_cin_msb;
    else if (is_shift) fl.of = sl_of;
    else               fl.of = 1'b0;
  end
  assign flags_now = fl;

  // registered flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_en) flags_q <= flags_now;
  end

  // ---------------- assertions ----------------
  p_flag_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |=> flags_q == $past(flags_now));
  p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> $stable(flags_q));
  p_byte_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !size_word |-> result[DATA_W-1:BYTE_W] == '0);
  p_logic_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |-> (flags_now[0] == 1'b0 && flags_now[5] == 1'b0 && flags_now[2] == 1'b0));
  p_cf_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cf_keep |-> flags_now[0] == carry_in);
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_now[3] == (result == '0));
  p_sign_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_now[4] == (size_word ? result[DATA_W-1] : result[BYTE_W-1]));
  p_rsvd_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    is_rsvd |-> (result == '0 && flags_now == 6'b001010));
  p_no_af_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_shift |-> flags_now[2] == 1'b0);

endmodule

// File: tb/alu_flags_unit_bench.sv
module alu_flags_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [3:0]  op_code = '0;
  logic        size_word = 1'b1, carry_in = 1'b0, flag_en = 1'b0;
  logic [15:0] result;
  logic [5:0]  flags_now, flags_q;
  logic        cf_keep;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_flags_unit u_alu_flags_unit (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_code(op_code),
    .size_word(size_word), .carry_in(carry_in), .flag_en(flag_en),
    .result(result), .flags_now(flags_now), .flags_q(flags_q), .cf_keep(cf_keep)
  );

  // reference: returns {keep, flags[5:0], result[15:0]}
  function automatic logic [22:0] model(input int unsigned a0, input int unsigned b0,
                                        input int op, input bit w, input bit cin);
    int unsigned width = w ? 16 : 8;
    int unsigned mask  = w ? 32'hFFFF : 32'hFF;
    int unsigned A = a0 & mask, B = b0 & mask, C = 0, r = 0;
    int unsigned sa, sb, sr;
    bit cf = 0, of = 0, af = 0, keep = 0, zf, sf, pf;
    int ones;
    case (op)
      0, 1, 7: begin
        if (op == 7) B = 1;
        if (op == 1) C = cin;
        r  = (A + B + C) & mask;
        cf = ((A + B + C) >> width) & 1;
        af = ((A & 15) + (B & 15) + C) > 15;
        sa = (A >> (width-1)) & 1; sb = (B >> (width-1)) & 1; sr = (r >> (width-1)) & 1;
        of = (sa == sb) && (sr != sa);
      end
      2, 3, 8: begin
        if (op == 8) B = 1;
        if (op == 3) C = cin;
        r  = (A - B - C) & mask;
        cf = A < (B + C);
        af = (A & 15) < ((B & 15) + C);
        sa = (A >> (width-1)) & 1; sb = (B >> (width-1)) & 1; sr = (r >> (width-1)) & 1;
        of = (sa != sb) && (sr != sa);
      end
      4: r = A & B;
      5: r = A | B;
      6: r = A ^ B;
      9: r = ~A & mask;
      10: begin
        r = (A << 1) & mask; cf = (A >> (width-1)) & 1;
        of = ((r >> (width-1)) & 1) ^ cf;
      end
      11: begin r = A >> 1; cf = A & 1; of = (A >> (width-1)) & 1; end
      12: begin r = (A >> 1) | (A & (1 << (width-1))); cf = A & 1; end
      default: r = 0;
    endcase
    if (op == 7 || op == 8 || op == 9) begin keep = 1; cf = cin; end
    zf = (r == 0);
    sf = (r >> (width-1)) & 1;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    pf = (ones % 2) == 0;
    return {keep, of, sf, zf, af, pf, cf, 16'(r)};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [22:0] act, input logic [22:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] a, input logic [15:0] b, input int op,
                         input bit w, input bit cin, input string tag);
    op_a = a; op_b = b; op_code = 4'(op); size_word = w; carry_in = cin;
    #5;
    check(tag, $sformatf("op%0d a=%h b=%h w=%0d c=%0d", op, a, b, w, cin),
          {cf_keep, flags_now, result}, model(a, b, op, w, cin));
  endtask

  task automatic t_reset;
    check("R11", "reset flags_q", {17'b0, flags_q}, 23'b0);
  endtask

  task automatic t_add;
    run_vec(16'hFFFF, 16'h0001, 0, 1, 0, "R1");
    run_vec(16'h1234, 16'h4321, 0, 1, 1, "R1");   // carry_in ignored
    run_vec(16'h0FFF, 16'h0001, 1, 1, 1, "R4");
    run_vec(16'h7FFF, 16'h0001, 0, 1, 0, "R3");
    run_vec(16'h8000, 16'h8000, 0, 1, 0, "R3");
    run_vec(16'hFFFF, 16'hFFFF, 1, 1, 1, "R1");
  endtask

  task automatic t_sub;
    run_vec(16'h0000, 16'h0001, 2, 1, 0, "R2");
    run_vec(16'h8000, 16'h0001, 2, 1, 0, "R3");
    run_vec(16'h0010, 16'h0001, 2, 1, 0, "R4");
    run_vec(16'h0005, 16'h0005, 3, 1, 1, "R2");
    run_vec(16'h0005, 16'h0005, 3, 1, 0, "R6");
  endtask

  task automatic t_byte;
    run_vec(16'hAB7F, 16'hCD01, 0, 0, 0, "R7");
    run_vec(16'h12FF, 16'h3401, 0, 0, 0, "R7");
    run_vec(16'hFF00, 16'h0001, 2, 0, 0, "R7");
    run_vec(16'hFF80, 16'h0000, 11, 0, 0, "R10");
  endtask

  task automatic t_parity;
    run_vec(16'h0100, 16'h0000, 5, 1, 0, "R5");
    run_vec(16'h7F03, 16'h0000, 5, 1, 0, "R5");
  endtask

  task automatic t_logic;
    run_vec(16'hF0F0, 16'hFF00, 4, 1, 1, "R8");
    run_vec(16'hF0F0, 16'h0F0F, 6, 1, 1, "R8");
    run_vec(16'h00F0, 16'h0F00, 5, 0, 1, "R8");
  endtask

  task automatic t_incdec;
    run_vec(16'hFFFF, 16'h0000, 7, 1, 0, "R9");
    run_vec(16'hFFFF, 16'h0000, 7, 1, 1, "R9");
    run_vec(16'h0000, 16'h0000, 8, 1, 0, "R9");
    run_vec(16'h0080, 16'h0000, 8, 0, 1, "R9");
    run_vec(16'h5A5A, 16'h0000, 9, 1, 1, "R9");
  endtask

  task automatic t_shift;
    run_vec(16'h8001, 16'h0000, 10, 1, 0, "R10");
    run_vec(16'h4000, 16'h0000, 10, 1, 0, "R10");
    run_vec(16'h8001, 16'h0000, 11, 1, 0, "R10");
    run_vec(16'h8001, 16'h0000, 12, 1, 0, "R10");
    run_vec(16'h00C1, 16'h0000, 12, 0, 1, "R10");
  endtask

  task automatic t_rsvd;
    for (int op = 13; op < 16; op++) run_vec(16'hABCD, 16'h1234, op, 1, 1, "R12");
  endtask

  task automatic t_regflags;
    logic [5:0] held;
    @(negedge clk);
    flag_en = 1'b1;
    run_vec(16'hFFFF, 16'h0001, 0, 1, 0, "R11");
    @(posedge clk); #2;
    check("R11", "flags_q load", {17'b0, flags_q}, {17'b0, model(16'hFFFF, 16'h0001, 0, 1, 0)[21:16]});
    held = flags_q;
    @(negedge clk);
    flag_en = 1'b0;
    run_vec(16'h0001, 16'h0001, 0, 1, 0, "R11");
    @(posedge clk); #2;
    check("R11", "flags_q hold", {17'b0, flags_q}, {17'b0, held});
  endtask

  task automatic t_sweep;
    logic [31:0] s = 32'h1ACE5EED;
    for (int i = 0; i < 2000; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      run_vec(s[15:0], s[31:16], int'(s[3:0] ^ s[23:20]), s[7], s[11], "R3");
    end
  endtask

  initial begin
    #1;
    t_reset;
    #40 rst_n = 1'b1;
    t_add;
    t_sub;
    t_byte;
    t_parity;
    t_logic;
    t_incdec;
    t_shift;
    t_rsvd;
    t_regflags;
    t_sweep;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule